// File: doc/BRIEF.md
# Four-Lane Vector Swizzle Unit

This block rearranges and combines the 32-bit lanes of 128-bit vector operands. A 3-bit opcode picks one of several cross-lane operations:

- **Shuffle** draws from two sources.
- **Permute** reorders a single source.
- **Blend** chooses lane by lane between two sources.
- **Pairwise add** sums neighbouring lanes.
- **Insert** writes a scalar into one lane.
- **Extract** reads one lane out as a scalar.

An 8-bit control operand carries the lane selectors, the blend mask or the lane index, depending on the opcode.

The datapath is combinational. An optional output register stage, on by default, gives a fixed latency of one clock. The lane count and lane width are parameters, and the default configuration is four lanes of 32 bits. Lane 0 occupies bits [31:0] of every vector port. A plain wrapping integer adder performs the pairwise sums.

Top module: `lane_swizzle_unit`

## Requirements
- R1: Opcode 1 (shuffle): field k of the control is bits [2k+1:2k] and names a source lane. Result lanes 0 and 1 take lane field(k) of operand a. Result lanes 2 and 3 take lane field(k) of operand b.
- R2: Opcode 2 (permute): result lane k is lane field(k) of operand a, for every k, with fields laid out as in R1.
- R3: Opcode 3 (blend): result lane k is lane k of operand b when control bit k is 1, and lane k of operand a when it is 0. Control bits 7:4 have no effect.
- R4: Opcode 4 (pairwise add): the result lanes are, from lane 0 up, a0+a1, a2+a3, b0+b1 and b2+b3. Each sum wraps modulo 2^32.
- R5: Opcode 5 (insert): the result is operand a with the lane addressed by control bits [1:0] replaced by the scalar input.
- R6: Opcode 6 (extract): the scalar result is the lane of operand a addressed by control bits [1:0], and the vector result is operand a unchanged.
- R7: For every opcode other than 6, the scalar result is zero.
- R8: Opcodes 0 and 7 return operand a unchanged as the vector result.
- R9: Insert and extract use only control bits [1:0] as the lane index. Control bits 7:2 have no effect on them.
- R10: With the output register enabled, results appear one clock after the inputs are applied. While reset is low, both results read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation select |
| vec_a_i | input | 128 | First vector operand |
| vec_b_i | input | 128 | Second vector operand |
| scalar_i | input | 32 | Scalar written by insert |
| ctrl_i | input | 8 | Lane selectors, blend mask or lane index |
| vec_o | output | 128 | Vector result |
| scalar_o | output | 32 | Scalar result |

## Verification
The hardest case to reach from the ports is a control operand whose bits mean different things to different opcodes. Upper control bits must be ignored by insert, extract and blend, yet they steer shuffle and permute. The stimulus therefore reuses the same control values across opcodes, with the high bits deliberately set wherever they should not matter. The pairwise add is driven with lanes near the top of the 32-bit range, so the sums wrap. The lane values are distinct per lane and per operand, so a misrouted lane shows up as a wrong value rather than a coincidental match.

// File: rtl/lane_swz_pkg.sv
package lane_swz_pkg;
   typedef enum logic [2:0] {
      SWZ_PASS_LO = 3'd0,
      SWZ_SHUF    = 3'd1,
      SWZ_PERM    = 3'd2,
      SWZ_BLEND   = 3'd3,
      SWZ_HADD    = 3'd4,
      SWZ_INS     = 3'd5,
      SWZ_EXT     = 3'd6,
      SWZ_PASS_HI = 3'd7
   } swz_op_e;
endpackage

// File: rtl/swz_lane_xbar.sv
// Each output lane independently selects any input lane.
module swz_lane_xbar #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4
) (
   input  logic [LANES*LANE_W-1:0]         src_i,
   input  logic [LANES*$clog2(LANES)-1:0]  sel_i,
   output logic [LANES*LANE_W-1:0]         dst_o
);
   localparam int SEL_W = $clog2(LANES);

   for (genvar k = 0; k < LANES; k++) begin : g_out
      logic [SEL_W-1:0] pick;
      assign pick = sel_i[k*SEL_W +: SEL_W];
      assign dst_o[k*LANE_W +: LANE_W] = src_i[pick*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/swz_pair_add.sv
// Adjacent-pair sums: a pairs fill the low half, b pairs the high half.
module swz_pair_add #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4
) (
   input  logic [LANES*LANE_W-1:0] a_i,
   input  logic [LANES*LANE_W-1:0] b_i,
   output logic [LANES*LANE_W-1:0] sum_o
);
   localparam int HALF = LANES / 2;

   for (genvar j = 0; j < HALF; j++) begin : g_pair
      assign sum_o[j*LANE_W +: LANE_W] =
         a_i[(2*j)*LANE_W +: LANE_W] + a_i[(2*j+1)*LANE_W +: LANE_W];
      assign sum_o[(HALF+j)*LANE_W +: LANE_W] =
         b_i[(2*j)*LANE_W +: LANE_W] + b_i[(2*j+1)*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/lane_swizzle_unit.sv
module lane_swizzle_unit
   import lane_swz_pkg::*;
#(
   parameter int LANE_W  = 32,
   parameter int LANES   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [2:0]                      op_i,
   input  logic [LANES*LANE_W-1:0]         vec_a_i,
   input  logic [LANES*LANE_W-1:0]         vec_b_i,
   input  logic [LANE_W-1:0]               scalar_i,
   input  logic [LANES*$clog2(LANES)-1:0]  ctrl_i,
   output logic [LANES*LANE_W-1:0]         vec_o,
   output logic [LANE_W-1:0]               scalar_o
);
   localparam int VEC_W  = LANES * LANE_W;
   localparam int SEL_W  = $clog2(LANES);
   localparam int HALF_W = VEC_W / 2;

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("LANE_W must be positive");
   end

   logic [SEL_W-1:0] lane_idx;
   assign lane_idx = ctrl_i[SEL_W-1:0];

   // Crossbars share the selector fields; shuffle splits halves between them
   logic [VEC_W-1:0] xb_a, xb_b, pair_sum, blend_vec, ins_vec;
   logic [LANE_W-1:0] ext_lane;

   swz_lane_xbar #(.LANE_W(LANE_W), .LANES(LANES)) u_xbar_a (
      .src_i(vec_a_i), .sel_i(ctrl_i), .dst_o(xb_a));
   swz_lane_xbar #(.LANE_W(LANE_W), .LANES(LANES)) u_xbar_b (
      .src_i(vec_b_i), .sel_i(ctrl_i), .dst_o(xb_b));
   swz_pair_add #(.LANE_W(LANE_W), .LANES(LANES)) u_pair (
      .a_i(vec_a_i), .b_i(vec_b_i), .sum_o(pair_sum));

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign blend_vec[k*LANE_W +: LANE_W] = ctrl_i[k] ? vec_b_i[k*LANE_W +: LANE_W]
                                                       : vec_a_i[k*LANE_W +: LANE_W];
      assign ins_vec[k*LANE_W +: LANE_W]   = (lane_idx == SEL_W'(k)) ? scalar_i
                                                       : vec_a_i[k*LANE_W +: LANE_W];
   end
   assign ext_lane = vec_a_i[lane_idx*LANE_W +: LANE_W];

   logic [VEC_W-1:0]  res_vec;
   logic [LANE_W-1:0] res_sca;

   always_comb begin
      res_vec = vec_a_i;
      res_sca = '0;
      case (swz_op_e'(op_i))
         SWZ_SHUF:  res_vec = {xb_b[VEC_W-1:HALF_W], xb_a[HALF_W-1:0]};
         SWZ_PERM:  res_vec = xb_a;
         SWZ_BLEND: res_vec = blend_vec;
         SWZ_HADD:  res_vec = pair_sum;
         SWZ_INS:   res_vec = ins_vec;
         SWZ_EXT:   res_sca = ext_lane;
         default:   res_vec = vec_a_i;
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vec_o    <= '0;
            scalar_o <= '0;
         end else begin
            vec_o    <= res_vec;
            scalar_o <= res_sca;
         end
      end

      // Independent lane mask for checking insert
      logic [VEC_W-1:0] chk_mask;
      assign chk_mask = {{(VEC_W-LANE_W){1'b0}}, {LANE_W{1'b1}}} << (lane_idx * LANE_W);

      a_r5_insert_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i == SWZ_INS) |=>
            ((vec_o & ~$past(chk_mask)) == ($past(vec_a_i) & ~$past(chk_mask))) &&
            ((vec_o & $past(chk_mask)) == ($past({LANES{scalar_i}}) & $past(chk_mask))));

      a_r6_extract_keeps_vec: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i == SWZ_EXT) |=> (vec_o == $past(vec_a_i)));

      a_r7_scalar_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i != SWZ_EXT) |=> (scalar_o == '0));

      a_r8_pass_unknown: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i == SWZ_PASS_LO || op_i == SWZ_PASS_HI) |=> (vec_o == $past(vec_a_i)));

      a_r3_blend_none: assert property (@(posedge clk) disable iff (!rst_n)
         (op_i == SWZ_BLEND && ctrl_i[LANES-1:0] == '0) |=> (vec_o == $past(vec_a_i)));
   end else begin : g_comb
      assign vec_o    = res_vec;
      assign scalar_o = res_sca;
   end
endmodule

// File: tb/lane_swizzle_unit_bench.sv
`timescale 1ns/1ps
module lane_swizzle_unit_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   op = 3'd0;
   logic [127:0] va = '0, vb = '0;
   logic [31:0]  sc = '0;
   logic [7:0]   ctrl = '0;
   logic [127:0] vec_o;
   logic [31:0]  scalar_o;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [127:0] vec;
      logic [31:0]  sca;
      string        tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   lane_swizzle_unit u_lane_swizzle_unit (
      .clk(clk), .rst_n(rst_n), .op_i(op), .vec_a_i(va), .vec_b_i(vb),
      .scalar_i(sc), .ctrl_i(ctrl), .vec_o(vec_o), .scalar_o(scalar_o));

   function automatic logic [31:0] ln(input logic [127:0] v, input int i);
      return v[i*32 +: 32];
   endfunction

   // Reference model written from the requirements
   function automatic exp_t model(input logic [2:0] o, input logic [127:0] a, b,
                                  input logic [31:0] s, input logic [7:0] c);
      exp_t e;
      int idx;
      e.vec = a;
      e.sca = '0;
      idx = int'(c[1:0]);
      case (o)
         3'd1: for (int k = 0; k < 4; k++)
                  e.vec[k*32 +: 32] = (k < 2) ? ln(a, int'(c[2*k +: 2])) : ln(b, int'(c[2*k +: 2]));
         3'd2: for (int k = 0; k < 4; k++) e.vec[k*32 +: 32] = ln(a, int'(c[2*k +: 2]));
         3'd3: for (int k = 0; k < 4; k++) e.vec[k*32 +: 32] = c[k] ? ln(b, k) : ln(a, k);
         3'd4: e.vec = {ln(b,2)+ln(b,3), ln(b,0)+ln(b,1), ln(a,2)+ln(a,3), ln(a,0)+ln(a,1)};
         3'd5: e.vec[idx*32 +: 32] = s;
         3'd6: e.sca = ln(a, idx);
         default: e.vec = a;
      endcase
      return e;
   endfunction

   task automatic drive(input logic [2:0] o, input logic [127:0] a, b,
                        input logic [31:0] s, input logic [7:0] c, input string tag);
      exp_t e;
      @(negedge clk);
      op = o; va = a; vb = b; sc = s; ctrl = c;
      e = model(o, a, b, s, c);
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: registered output (R10) shows the previous cycle's inputs
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (vec_o !== e.vec || scalar_o !== e.sca) begin
               errors++;
               $display("FAIL %s vec %h sca %h expected vec %h sca %h",
                        e.tag, vec_o, scalar_o, e.vec, e.sca);
            end
         end
      end
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL R10 watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   logic [127:0] A, B, BIG_A, BIG_B;
   initial begin
      A = {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000};
      B = {32'hB000_0003, 32'hB000_0002, 32'hB000_0001, 32'hB000_0000};
      BIG_A = {32'h8000_0000, 32'h8000_0001, 32'h0000_0002, 32'hFFFF_FFFF};
      BIG_B = {32'h0000_0010, 32'h0000_0020, 32'hFFFF_FFF0, 32'h1234_5678};

      // R10: outputs held at zero in reset even with live inputs
      va = A; op = 3'd2; sc = 32'h55;
      #12;
      checks++;
      if (vec_o !== '0 || scalar_o !== '0) begin
         errors++;
         $display("FAIL R10 reset vec %h sca %h expected 0 0", vec_o, scalar_o);
      end
      @(negedge clk);
      rst_n = 1'b1;

      drive(3'd1, A, B, 32'h0, 8'b01_00_11_10, "R1 shuffle mixed");
      drive(3'd1, A, B, 32'h0, 8'hE4,          "R1 shuffle identity");
      drive(3'd2, A, B, 32'h0, 8'h1B,          "R2 permute reverse");
      drive(3'd2, A, B, 32'h0, 8'hAA,          "R2 permute broadcast lane2");
      drive(3'd3, A, B, 32'h0, 8'hFA,          "R3 blend 1010 high bits set");
      drive(3'd3, A, B, 32'h0, 8'hF0,          "R3 blend all a");
      drive(3'd3, A, B, 32'h0, 8'h0F,          "R3 blend all b");
      drive(3'd4, A, B, 32'h0, 8'h00,          "R4 pair add");
      drive(3'd4, BIG_A, BIG_B, 32'h0, 8'hFF,  "R4 pair add wrap");
      drive(3'd5, A, B, 32'hCAFE_0000, 8'h00,  "R5 insert lane0");
      drive(3'd5, A, B, 32'hCAFE_0003, 8'hFF,  "R5 R9 insert lane3 high bits");
      drive(3'd6, A, B, 32'h1111_1111, 8'hF6,  "R6 R9 extract lane2 high bits");
      drive(3'd6, BIG_A, B, 32'h0, 8'h01,      "R6 extract lane1");
      drive(3'd2, A, B, 32'hFFFF_FFFF, 8'h00,  "R7 scalar zero on permute");
      drive(3'd0, A, B, 32'h0, 8'h1B,          "R8 opcode 0 pass");
      drive(3'd7, BIG_A, B, 32'h0, 8'hE4,      "R8 opcode 7 pass");

      @(negedge clk);
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule